// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits behind a two-wire memory slave and turns the byte stream of a write command into one array programming operation. The slave hands it a starting word address, then one strobe per received data byte, and finally either a STOP or a fresh START. Bytes land in a 32-entry page latch at an offset that advances by one per byte. Only the offset bits advance. The page part of the address never changes within a command, so a long burst wraps to the start of the same page and replaces bytes latched earlier.

A STOP that closes a command holding at least one byte starts a self-timed commit, provided the write-protect input is low. Busy is raised for a fixed number of clocks. During the first 32 cycles of that window, every byte marked valid in the latch is driven onto a simple array write port, one byte per cycle. Bytes never received are not written. A START that closes the command, as in the address phase of a random read, drops the latch with no commit. While busy, all command inputs are ignored. This lets the slave withhold its acknowledge and implement acknowledge polling.

Top module: `page_commit_buf`

## Requirements
- R1: After reset, busy_o is low, arr_we_o is low and the latch holds no valid bytes.
- R2: addr_load_i sets the page from addr_i[11:5] and the offset from addr_i[4:0]. Each data strobe stores data_i at the current offset and then adds one to the offset modulo 32. The page bits never change, so a burst that crosses offset 31 continues at offset 0 of the same page.
- R3: When more than 32 bytes arrive before STOP, a later byte at an offset replaces the earlier one, and only the last value per offset is committed.
- R4: A commit starts only on a STOP received while idle with at least one latched byte. A STOP with an empty latch leaves busy_o low and the array untouched.
- R5: busy_o rises in the cycle after the accepted STOP and stays high for exactly max(WR_CYCLES, 32) consecutive cycles.
- R6: During a commit, the array receives one write for each offset marked valid, at address {page, offset}, carrying the latched byte. Addresses not written keep their contents, and arr_we_o is never high while busy_o is low.
- R7: If wp_i is high when STOP is accepted, no commit occurs: busy_o stays low, the array is unchanged and the latch is emptied.
- R8: A START (start_i) while idle empties the latch without a commit, so a following STOP with no new data does nothing.
- R9: While busy_o is high, addr_load_i, data_strobe_i, stop_i and start_i have no effect on the latch, the pointer or the commit in progress.
- R10: When a commit completes, the latch is emptied, so a later STOP with no new data does not start another commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_i | input | 1 | Write protect; when high at STOP, the commit is suppressed |
| addr_load_i | input | 1 | Load the word address (start of a write command) |
| addr_i | input | 12 | Word address loaded by addr_load_i |
| data_strobe_i | input | 1 | One received data byte is present on data_i |
| data_i | input | 8 | Received data byte |
| stop_i | input | 1 | STOP seen on the bus |
| start_i | input | 1 | START seen on the bus, ending the command without a STOP |
| busy_o | output | 1 | Self-timed commit in progress |
| arr_we_o | output | 1 | Array byte write enable |
| arr_addr_o | output | 12 | Array byte address |
| arr_data_o | output | 8 | Array byte write data |

## Verification
The assertions take for granted that the bus slave raises at most one of addr_load_i, data_strobe_i, stop_i and start_i in any cycle, and one assertion checks this at the inputs. The stimulus drives each event as a single-cycle pulse from its own task, so no two events ever share a cycle. The bench also holds wp_i steady for a whole command, so the value seen at STOP is the one the reference model uses. Random commands vary the start offset, the length (zero to beyond two pages' worth of wraps), the protect level and the closing event. Directed cases inject every control pulse while a commit is running.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    localparam int PCB_ADDR_W     = 12;
    localparam int PCB_DATA_W     = 8;
    localparam int PCB_PAGE_BYTES = 32;

    // Decoded bus event for one cycle
    typedef enum logic [2:0] {
        EV_NONE,
        EV_LOAD,
        EV_DATA,
        EV_STOP,
        EV_ABORT
    } bus_ev_e;

    // One byte-wide request toward the array
    typedef struct packed {
        logic                  we;
        logic [PCB_ADDR_W-1:0] addr;
        logic [PCB_DATA_W-1:0] data;
    } arr_wr_t;

    // Ending events win over data so a malformed overlap never commits stale state
    function automatic bus_ev_e ev_decode(logic ld, logic dt, logic sp, logic st);
        bus_ev_e ev;
        if (sp)      ev = EV_STOP;
        else if (st) ev = EV_ABORT;
        else if (ld) ev = EV_LOAD;
        else if (dt) ev = EV_DATA;
        else         ev = EV_NONE;
        return ev;
    endfunction

    // Busy window must at least cover one slot per page byte
    function automatic int run_len(int wr_cycles, int page_bytes);
        return (wr_cycles > page_bytes) ? wr_cycles : page_bytes;
    endfunction

endpackage

// File: rtl/pcb_pointer.sv
module pcb_pointer #(
    parameter int ADDR_W     = pcb_pkg::PCB_ADDR_W,
    parameter int PAGE_BYTES = pcb_pkg::PCB_PAGE_BYTES,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              adv_i,
    output logic [PAGE_W-1:0] page_o,
    output logic [OFF_W-1:0]  off_o
);

    logic [PAGE_W-1:0] page_q;
    logic [OFF_W-1:0]  off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            off_q  <= '0;
        end else if (load_i) begin
            page_q <= addr_i[ADDR_W-1:OFF_W];
            off_q  <= addr_i[OFF_W-1:0];
        end else if (adv_i) begin
            off_q  <= off_q + 1'b1;   // only the in-page bits move
        end
    end

    assign page_o = page_q;
    assign off_o  = off_q;

    // R2: a data byte never moves the page
    p_page_fixed_r2: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !load_i) |=> $stable(page_q));

    // R2: a data byte always moves the offset
    p_off_moves_r2: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !load_i) |=> !$stable(off_q));

endmodule

// File: rtl/pcb_latch.sv
module pcb_latch #(
    parameter int DATA_W     = pcb_pkg::PCB_DATA_W,
    parameter int PAGE_BYTES = pcb_pkg::PCB_PAGE_BYTES,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [OFF_W-1:0]  wr_off_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              clr_i,
    input  logic              hold_i,
    input  logic [OFF_W-1:0]  rd_off_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              any_o
);

    logic [PAGE_BYTES-1:0][DATA_W-1:0] mem_q;
    logic [PAGE_BYTES-1:0]             vld_q;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q[g] <= 1'b0;
                mem_q[g] <= '0;
            end else if (clr_i) begin
                vld_q[g] <= 1'b0;
            end else if (wr_i && (wr_off_i == OFF_W'(g))) begin
                vld_q[g] <= 1'b1;
                mem_q[g] <= wr_data_i;   // a repeat visit replaces the older byte
            end
        end
    end

    assign rd_data_o  = mem_q[rd_off_i];
    assign rd_valid_o = vld_q[rd_off_i];
    assign any_o      = |vld_q;

    // R9: nothing in the latch changes while a commit holds it
    p_latch_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (hold_i && !clr_i) |=> ($stable(mem_q) && $stable(vld_q)));

    // R10: an emptied latch reports no valid byte
    p_clear_empties_r10: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !any_o);

endmodule

// File: rtl/pcb_timer.sv
module pcb_timer #(
    parameter int WR_CYCLES  = 625000,
    parameter int PAGE_BYTES = pcb_pkg::PCB_PAGE_BYTES,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int RUN       = pcb_pkg::run_len(WR_CYCLES, PAGE_BYTES),
    localparam int CNT_W     = $clog2(RUN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_i,
    output logic             busy_o,
    output logic [OFF_W-1:0] slot_o,
    output logic             slot_ok_o,
    output logic             done_o
);

    typedef enum logic {T_IDLE, T_RUN} tstate_e;

    localparam logic [CNT_W-1:0] SLOTS = CNT_W'(PAGE_BYTES);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(RUN - 1);

    tstate_e          st_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= T_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                T_IDLE: if (go_i) begin
                    st_q  <= T_RUN;
                    cnt_q <= '0;
                end
                T_RUN: if (cnt_q == LAST) begin
                    st_q  <= T_IDLE;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                default: st_q <= T_IDLE;
            endcase
        end
    end

    assign busy_o    = (st_q == T_RUN);
    assign slot_o    = cnt_q[OFF_W-1:0];
    assign slot_ok_o = busy_o && (cnt_q < SLOTS);
    assign done_o    = busy_o && (cnt_q == LAST);

    // R5: an accepted start opens the window at its first slot
    p_window_opens_r5: assert property (@(posedge clk) disable iff (rst)
        go_i |=> (busy_o && cnt_q == '0));

    // R5: the counter never runs past the window
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (cnt_q <= LAST));

endmodule

// File: rtl/page_commit_buf.sv
module page_commit_buf
    import pcb_pkg::*;
#(
    parameter int WR_CYCLES = 625000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wp_i,
    input  logic                  addr_load_i,
    input  logic [PCB_ADDR_W-1:0] addr_i,
    input  logic                  data_strobe_i,
    input  logic [PCB_DATA_W-1:0] data_i,
    input  logic                  stop_i,
    input  logic                  start_i,
    output logic                  busy_o,
    output logic                  arr_we_o,
    output logic [PCB_ADDR_W-1:0] arr_addr_o,
    output logic [PCB_DATA_W-1:0] arr_data_o
);

    localparam int OFF_W  = $clog2(PCB_PAGE_BYTES);
    localparam int PAGE_W = PCB_ADDR_W - OFF_W;
    localparam int RUN    = run_len(WR_CYCLES, PCB_PAGE_BYTES);
    localparam int LEN_W  = $clog2(RUN + 2);

    bus_ev_e           ev;
    logic              idle;
    logic              ld_en, dt_en, go, clr;
    logic [PAGE_W-1:0] page;
    logic [OFF_W-1:0]  off;
    logic [OFF_W-1:0]  slot;
    logic              slot_ok, done, busy;
    logic [PCB_DATA_W-1:0] rd_data;
    logic              rd_valid, any;
    arr_wr_t           req;

    assign ev    = ev_decode(addr_load_i, data_strobe_i, stop_i, start_i);
    assign idle  = !busy;
    assign ld_en = idle && (ev == EV_LOAD);
    assign dt_en = idle && (ev == EV_DATA);
    assign go    = idle && (ev == EV_STOP) && any && !wp_i;
    assign clr   = done
                 || (idle && (ev == EV_LOAD || ev == EV_ABORT))
                 || (idle && ev == EV_STOP && !go);

    pcb_pointer #(
        .ADDR_W     (PCB_ADDR_W),
        .PAGE_BYTES (PCB_PAGE_BYTES)
    ) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .load_i (ld_en),
        .addr_i (addr_i),
        .adv_i  (dt_en),
        .page_o (page),
        .off_o  (off)
    );

    pcb_latch #(
        .DATA_W     (PCB_DATA_W),
        .PAGE_BYTES (PCB_PAGE_BYTES)
    ) u_lat (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (dt_en),
        .wr_off_i   (off),
        .wr_data_i  (data_i),
        .clr_i      (clr),
        .hold_i     (busy),
        .rd_off_i   (slot),
        .rd_data_o  (rd_data),
        .rd_valid_o (rd_valid),
        .any_o      (any)
    );

    pcb_timer #(
        .WR_CYCLES  (WR_CYCLES),
        .PAGE_BYTES (PCB_PAGE_BYTES)
    ) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .go_i      (go),
        .busy_o    (busy),
        .slot_o    (slot),
        .slot_ok_o (slot_ok),
        .done_o    (done)
    );

    always_comb begin
        req.we   = slot_ok && rd_valid;
        req.addr = {page, slot};
        req.data = rd_data;
    end

    assign busy_o     = busy;
    assign arr_we_o   = req.we;
    assign arr_addr_o = req.addr;
    assign arr_data_o = req.data;

    // Busy-length tracker used by the checks below
    logic [LEN_W-1:0] len_q;
    always_ff @(posedge clk) begin
        if (rst || !busy_o) len_q <= '0;
        else                len_q <= len_q + 1'b1;
    end

    // Input contract: the slave reports at most one event per cycle
    p_one_event_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({addr_load_i, data_strobe_i, stop_i, start_i}));

    // R5: every busy window has the full length
    p_busy_len_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (len_q == LEN_W'(RUN)));

    // R6: the array is only touched inside a commit
    p_we_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
        arr_we_o |-> busy_o);

    // R6: a commit stays on one page
    p_one_page_r6: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(arr_addr_o[PCB_ADDR_W-1:OFF_W]));

    // R7: protect suppresses the commit
    p_wp_block_r7: assert property (@(posedge clk) disable iff (rst)
        (stop_i && wp_i && !busy_o) |=> !busy_o);

    // R4: an empty latch never commits
    p_empty_stop_r4: assert property (@(posedge clk) disable iff (rst)
        (stop_i && !busy_o && !any) |=> !busy_o);

endmodule

// File: tb/tb_page_commit_buf.sv
module tb_page_commit_buf;

    localparam int WR  = 48;
    localparam int LEN = (WR > 32) ? WR : 32;
    localparam int WD  = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wp_i = 1'b0;
    logic        addr_load_i = 1'b0;
    logic [11:0] addr_i = '0;
    logic        data_strobe_i = 1'b0;
    logic [7:0]  data_i = '0;
    logic        stop_i = 1'b0;
    logic        start_i = 1'b0;
    logic        busy_o, arr_we_o;
    logic [11:0] arr_addr_o;
    logic [7:0]  arr_data_o;

    always #4 clk = ~clk;   // 125 MHz

    page_commit_buf #(.WR_CYCLES(WR)) dut (
        .clk(clk), .rst(rst), .wp_i(wp_i),
        .addr_load_i(addr_load_i), .addr_i(addr_i),
        .data_strobe_i(data_strobe_i), .data_i(data_i),
        .stop_i(stop_i), .start_i(start_i),
        .busy_o(busy_o), .arr_we_o(arr_we_o),
        .arr_addr_o(arr_addr_o), .arr_data_o(arr_data_o)
    );

    int total = 0;
    int bad   = 0;

    logic [7:0] arr_mem [4096];   // array driven by the design
    logic [7:0] exp_mem [4096];   // expected contents
    logic [7:0] ref_buf [32];
    logic [31:0] ref_mask;
    logic [6:0]  ref_page;
    logic [4:0]  ref_off;
    bit          exp_busy;

    function automatic logic [7:0] init_val(logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
    endfunction

    always @(posedge clk)
        if (arr_we_o) arr_mem[arr_addr_o] <= arr_data_o;

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic op_load(logic [11:0] a);
        addr_load_i = 1'b1; addr_i = a;
        @(negedge clk);
        addr_load_i = 1'b0;
        if (!exp_busy) begin
            ref_page = a[11:5]; ref_off = a[4:0]; ref_mask = '0;
        end
    endtask

    task automatic op_data(logic [7:0] d);
        data_strobe_i = 1'b1; data_i = d;
        @(negedge clk);
        data_strobe_i = 1'b0;
        if (!exp_busy) begin
            ref_buf[ref_off] = d; ref_mask[ref_off] = 1'b1; ref_off = ref_off + 1'b1;
        end
    endtask

    task automatic op_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (!exp_busy) ref_mask = '0;
    endtask

    task automatic op_stop(string tag);
        bit was_busy = exp_busy;
        bit commit   = (ref_mask != 0) && !wp_i && !was_busy;
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        if (!was_busy) begin
            chk(busy_o == commit, tag, busy_o, commit);
            if (commit) begin
                for (int i = 0; i < 32; i++)
                    if (ref_mask[i]) exp_mem[{ref_page, 5'(i)}] = ref_buf[i];
                exp_busy = 1'b1;
            end
            ref_mask = '0;
        end
    endtask

    task automatic compare_mem(string tag);
        int nbad = 0;
        int first = -1;
        for (int a = 0; a < 4096; a++)
            if (arr_mem[a] !== exp_mem[a]) begin
                nbad++;
                if (first < 0) first = a;
            end
        if (first < 0) chk(1'b1, tag, 0, 0);
        else chk(1'b0, {tag, " array byte"}, arr_mem[first], exp_mem[first]);
    endtask

    task automatic wait_commit(int already);
        int n = already;
        if (!exp_busy) return;
        while (busy_o && n < LEN + 10) begin
            n++;
            @(negedge clk);
        end
        chk(n == LEN, "R5 busy length", n, LEN);
        exp_busy = 1'b0;
        compare_mem("R6 committed contents");
    endtask

    initial begin
        void'($urandom(32'h1BADC0DE));
        for (int a = 0; a < 4096; a++) begin
            arr_mem[a] = init_val(12'(a));
            exp_mem[a] = init_val(12'(a));
        end
        ref_mask = '0; ref_page = '0; ref_off = '0; exp_busy = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);
        chk(arr_we_o == 1'b0, "R1 we after reset", arr_we_o, 0);
        op_stop("R1 stop with empty latch after reset");

        // R4 single byte
        op_load(12'h123);
        op_data(8'h77);
        op_stop("R4 single byte commit");
        wait_commit(0);
        chk(arr_mem[12'h123] == 8'h77, "R4 single byte value", arr_mem[12'h123], 8'h77);
        chk(arr_mem[12'h124] == init_val(12'h124), "R6 neighbour kept",
            arr_mem[12'h124], init_val(12'h124));

        // R2 wrap and R3 overwrite: 40 bytes from offset 30
        op_load(12'h3DE);
        for (int i = 0; i < 40; i++) op_data(8'(8'hA0 + i));
        op_stop("R3 long burst commit");
        wait_commit(0);
        chk(arr_mem[12'h3DE] == 8'hC0, "R3 later byte wins", arr_mem[12'h3DE], 8'hC0);
        chk(arr_mem[12'h3C6] == 8'hA8, "R2 wrapped to page start", arr_mem[12'h3C6], 8'hA8);
        chk(arr_mem[12'h3E0] == init_val(12'h3E0), "R2 next page untouched",
            arr_mem[12'h3E0], init_val(12'h3E0));

        // R7 write protect
        wp_i = 1'b1;
        op_load(12'h500);
        for (int i = 0; i < 5; i++) op_data(8'hEE);
        op_stop("R7 protected stop");
        wp_i = 1'b0;
        repeat (LEN) @(negedge clk);
        compare_mem("R7 array unchanged");
        op_stop("R7 latch emptied after protected stop");

        // R8 start discards
        op_load(12'h640);
        op_data(8'h11); op_data(8'h22);
        op_start();
        op_stop("R8 stop after discard");
        compare_mem("R8 array unchanged");

        // R9 events during busy, then R10 empty after commit
        op_load(12'h7F0);
        op_data(8'h5C);
        op_stop("R9 commit before busy events");
        op_load(12'h000);
        op_data(8'h99);
        op_data(8'h98);
        op_stop("R9 stop while busy");
        op_start();
        op_data(8'h97);
        wait_commit(6);
        chk(arr_mem[12'h000] == init_val(12'h000), "R9 busy data ignored",
            arr_mem[12'h000], init_val(12'h000));
        op_stop("R10 stop after completed commit");
        compare_mem("R10 array unchanged");

        // Random commands
        for (int t = 0; t < 220; t++) begin
            int n = ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(1, 70);
            wp_i = ($urandom_range(0, 4) == 0);
            op_load(12'($urandom));
            for (int i = 0; i < n; i++) op_data(8'($urandom));
            if ($urandom_range(0, 5) == 0) op_start();
            op_stop("R4 random stop");
            wait_commit(0);
            compare_mem("R2 random contents");
        end
        wp_i = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WD, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule